// File: doc/BRIEF.md
# Write Status Polling Responder

This block stands in for the internal program/erase sequencer of a parallel flash device. A host-side command decoder, which is not part of this block, issues a single start strobe with an operation kind (word program, sector erase, block erase or chip erase), a target address and, for a program, the word to store. The block then holds `busy` for a fixed number of clock ticks chosen by the operation kind. In the last busy cycle it raises `done` for one cycle and applies the result to a small behavioural word array in that same cycle. A program writes the target word. An erase sets every word of the addressed region to all-ones.

While `busy` is high, every read returns a status word in place of array contents. Bit 7 is the polling bit: it is the inverse of bit 7 of the word being programmed, and it is 0 during any erase. Bit 6 is a toggle bit that inverts on each read. All other bits read as 0. Once the operation ends, reads return array data again, so bit 6 no longer alternates and bit 7 shows the stored value.

Top module: `wr_status_resp`

## Requirements
- R1: After reset `busy`, `done` and `rd_valid` are 0, and every array word reads 0000h.
- R2: A start strobe taken while idle with kind 0 (word program) holds `busy` high for exactly PROG_TICKS cycles, starting the cycle after the strobe. `done` is high only in the last of those cycles.
- R3: Kind 1 (sector erase), kind 2 (block erase) and kind 3 (chip erase) hold `busy` for SECT_TICKS, BLK_TICKS and CHIP_TICKS cycles. `done` is high in the last busy cycle.
- R4: A read issued while a program is busy returns a word with bit 7 equal to the inverse of bit 7 of the programmed data. All bits other than 7 and 6 are 0.
- R5: A read issued while any erase is busy returns bit 7 = 0. All bits other than 7 and 6 are 0.
- R6: During a busy operation bit 6 is 0 on the first read after the start and inverts on each further read. Once idle, repeated reads of one word return identical data.
- R7: After a program completes, the target address reads back the programmed word.
- R8: A sector erase sets to FFFFh the 2^SECT_W words that share the target's address bits above bit SECT_W-1. Words outside that region are unchanged.
- R9: A block erase sets to FFFFh the 2^BLK_W words that share the target's address bits above bit BLK_W-1. Words outside that region are unchanged.
- R10: A chip erase sets every word of the array to FFFFh.
- R11: A start strobe that arrives while `busy` is high is ignored. The running operation keeps its duration, kind and target.
- R12: A read asserted with `rd_en` in cycle n gives `rd_valid` = 1 and its data in cycle n+1. The data reflects the busy state of cycle n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle strobe that launches an operation |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr | input | ADDR_W | Target word address |
| op_data | input | DATA_W | Word to program |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read result, array word or status |
| rd_valid | output | 1 | rd_data holds a fresh result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last busy cycle; array is written on this edge |

## Verification
A counter that is loaded wrongly or skips a step shows at once as a wrong `busy` length. The bench checks this for every operation kind. A latched kind or address that is corrupted mid-operation shows either in the polling bit of the next read or in the region found erased after `done`. A toggle flop that advances without a read, or fails to clear on a start, gives a wrong bit 6 on the very next status read. Stray region-match logic shows on the words just outside each erased region, which the bench reads back.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } wr_op_e;
endpackage

// File: rtl/wsp_timer.sv
module wsp_timer
  import wsp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int PROG_TICKS = 8,
  parameter int SECT_TICKS = 20,
  parameter int BLK_TICKS  = 30,
  parameter int CHIP_TICKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  wr_op_e            op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output wr_op_e            op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int MAX_A  = (PROG_TICKS > SECT_TICKS) ? PROG_TICKS : SECT_TICKS;
  localparam int MAX_B  = (BLK_TICKS > CHIP_TICKS) ? BLK_TICKS : CHIP_TICKS;
  localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_T + 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  wr_op_e            op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              launch;
  logic [CNT_W-1:0]  load_val;

  assign launch = start_i && !busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_comb begin
    case (op_i)
      OP_PROG: load_val = CNT_W'(PROG_TICKS - 1);
      OP_SECT: load_val = CNT_W'(SECT_TICKS - 1);
      OP_BLK:  load_val = CNT_W'(BLK_TICKS - 1);
      default: load_val = CNT_W'(CHIP_TICKS - 1);
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    addr_d = addr_q;
    data_d = data_q;
    if (launch) begin
      busy_d = 1'b1;
      cnt_d  = load_val;
      op_d   = op_i;
      addr_d = addr_i;
      data_d = data_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> busy_q);
  p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_q);
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_o) |=> (busy_q && $stable(op_q) && $stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/wsp_status.sv
module wsp_status #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic              tgt_b7_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int POLL_BIT = 7;
  localparam int TGL_BIT  = 6;

  logic              tgl_q, tgl_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              rval_q;
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word           = '0;
    stat_word[POLL_BIT] = erase_i ? 1'b0 : ~tgt_b7_i;
    stat_word[TGL_BIT]  = tgl_q;
  end

  always_comb begin
    tgl_d = tgl_q;
    if (launch_i)                tgl_d = 1'b0;
    else if (rd_en_i && busy_i)  tgl_d = ~tgl_q;
    rdat_d = busy_i ? stat_word : arr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q  <= 1'b0;
      rdat_q <= '0;
      rval_q <= 1'b0;
    end else begin
      tgl_q  <= tgl_d;
      rval_q <= rd_en_i;
      if (rd_en_i) rdat_q <= rdat_d;
    end
  end

  assign rd_data_o  = rdat_q;
  assign rd_valid_o = rval_q;

  p_tgl_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && busy_i && !launch_i) |=> (tgl_q != $past(tgl_q)));
  p_tgl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && !launch_i) |=> $stable(tgl_q));
  p_erase_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && busy_i && erase_i) |=> !rd_data_o[POLL_BIT]);
  p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);
endmodule

// File: rtl/wsp_array.sv
module wsp_array
  import wsp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SECT_W = 3,
  parameter int BLK_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  wr_op_e            op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] WADR = ADDR_W'(g);
    always_comb begin
      case (op_i)
        OP_PROG: hit[g] = (WADR == addr_i);
        OP_SECT: hit[g] = (WADR[ADDR_W-1:SECT_W] == addr_i[ADDR_W-1:SECT_W]);
        OP_BLK:  hit[g] = (WADR[ADDR_W-1:BLK_W] == addr_i[ADDR_W-1:BLK_W]);
        default: hit[g] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hit[i]) mem[i] <= (op_i == OP_PROG) ? data_i : '1;
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];

  p_chip_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && op_i == OP_CHIP) |=> ((mem[0] == '1) && (mem[DEPTH-1] == '1)));
endmodule

// File: rtl/wr_status_resp.sv
module wr_status_resp
  import wsp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int SECT_W     = 3,
  parameter int BLK_W      = 5,
  parameter int PROG_TICKS = 8,
  parameter int SECT_TICKS = 20,
  parameter int BLK_TICKS  = 30,
  parameter int CHIP_TICKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done
);
  wr_op_e            cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;
  logic [DATA_W-1:0] arr_word;
  logic              launch;

  assign launch = op_start && !busy;

  wsp_timer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PROG_TICKS(PROG_TICKS), .SECT_TICKS(SECT_TICKS),
    .BLK_TICKS(BLK_TICKS), .CHIP_TICKS(CHIP_TICKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start_i(op_start), .op_i(wr_op_e'(op_kind)),
    .addr_i(op_addr), .data_i(op_data),
    .busy_o(busy), .done_o(done),
    .op_o(cur_op), .addr_o(cur_addr), .data_o(cur_data)
  );

  wsp_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .launch_i(launch), .busy_i(busy),
    .erase_i(cur_op != OP_PROG), .tgt_b7_i(cur_data[7]),
    .rd_en_i(rd_en), .arr_data_i(arr_word),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  wsp_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .BLK_W(BLK_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_i(done), .op_i(cur_op),
    .addr_i(cur_addr), .data_i(cur_data),
    .rd_addr_i(rd_addr), .rd_data_o(arr_word)
  );
endmodule

// File: tb/wr_status_resp_tb_top.sv
module wr_status_resp_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int PT = 8;
  localparam int ST = 20;
  localparam int BT = 30;
  localparam int CT = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_start = 1'b0;
  logic [1:0]    op_kind = 2'd0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          busy;
  logic          done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wr_status_resp #(
    .ADDR_W(AW), .DATA_W(DW), .SECT_W(3), .BLK_W(5),
    .PROG_TICKS(PT), .SECT_TICKS(ST), .BLK_TICKS(BT), .CHIP_TICKS(CT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_op(input logic [1:0] kind, input logic [AW-1:0] a, input logic [DW-1:0] d);
    op_start = 1'b1; op_kind = kind; op_addr = a; op_data = d;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R12 rd_valid", 32'(rd_valid), 32'd1);
    d = rd_data;
  endtask

  task automatic wait_idle(output int n, output int done_at);
    n = 0; done_at = -1;
    while (busy) begin
      n++;
      if (done) done_at = n;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    rd(8'h20, d);
    chk("R1 array zero", 32'(d), 0);
  endtask

  task automatic t_prog_timing();
    int n, da;
    logic [DW-1:0] d;
    start_op(2'd0, 8'h0F, 16'hA5A5);
    wait_idle(n, da);
    chk("R2 busy length", n, PT);
    chk("R2 done last cycle", da, PT);
    rd(8'h0F, d);
    chk("R7 readback", 32'(d), 32'hA5A5);
  endtask

  task automatic t_prog_status();
    int n, da;
    logic [DW-1:0] d;
    start_op(2'd0, 8'h10, 16'h1280);
    rd(8'h10, d);  chk("R4 poll inv of 1", 32'(d), 32'h0000);
    rd(8'h33, d);  chk("R6 toggle second read", 32'(d), 32'h0040);
    rd(8'h10, d);  chk("R6 toggle third read", 32'(d), 32'h0000);
    wait_idle(n, da);
    chk("R2 busy length with reads", n + 3, PT);
    rd(8'h10, d);  chk("R7 readback", 32'(d), 32'h1280);
    rd(8'h10, d);  chk("R6 stable when idle", 32'(d), 32'h1280);
    start_op(2'd0, 8'h18, 16'h0055);
    rd(8'h18, d);  chk("R4 poll inv of 0", 32'(d), 32'h0080);
    rd(8'h18, d);  chk("R6 toggle restarts", 32'(d), 32'h00C0);
    wait_idle(n, da);
    rd(8'h18, d);  chk("R7 readback 2", 32'(d), 32'h0055);
  endtask

  task automatic t_sector();
    int n, da;
    logic [DW-1:0] d;
    start_op(2'd1, 8'h13, 16'h0000);
    rd(8'h13, d);  chk("R5 erase poll", 32'(d), 32'h0000);
    rd(8'h13, d);  chk("R5 erase poll toggled", 32'(d), 32'h0040);
    wait_idle(n, da);
    chk("R3 sector length", n + 2, ST);
    chk("R3 sector done last", da, n);
    rd(8'h10, d);  chk("R8 low edge", 32'(d), 32'hFFFF);
    rd(8'h17, d);  chk("R8 high edge", 32'(d), 32'hFFFF);
    rd(8'h0F, d);  chk("R8 below kept", 32'(d), 32'hA5A5);
    rd(8'h18, d);  chk("R8 above kept", 32'(d), 32'h0055);
  endtask

  task automatic t_block();
    int n, da;
    logic [DW-1:0] d;
    start_op(2'd0, 8'h3F, 16'h1111); wait_idle(n, da);
    start_op(2'd0, 8'h60, 16'h2222); wait_idle(n, da);
    start_op(2'd0, 8'h50, 16'h4444); wait_idle(n, da);
    start_op(2'd2, 8'h45, 16'h0000);
    wait_idle(n, da);
    chk("R3 block length", n, BT);
    chk("R3 block done last", da, BT);
    rd(8'h40, d);  chk("R9 low edge", 32'(d), 32'hFFFF);
    rd(8'h50, d);  chk("R9 inside", 32'(d), 32'hFFFF);
    rd(8'h5F, d);  chk("R9 high edge", 32'(d), 32'hFFFF);
    rd(8'h3F, d);  chk("R9 below kept", 32'(d), 32'h1111);
    rd(8'h60, d);  chk("R9 above kept", 32'(d), 32'h2222);
  endtask

  task automatic t_ignore();
    int n, da;
    logic [DW-1:0] d;
    start_op(2'd0, 8'h00, 16'h3333);
    start_op(2'd3, 8'h3F, 16'h0000);
    rd(8'h00, d);  chk("R11 still program poll", 32'(d), 32'h0080);
    wait_idle(n, da);
    chk("R11 length unchanged", n + 2, PT);
    rd(8'h00, d);  chk("R11 target kept", 32'(d), 32'h3333);
    rd(8'h3F, d);  chk("R11 no chip erase", 32'(d), 32'h1111);
    chk("R11 idle after", 32'(busy), 0);
  endtask

  task automatic t_chip();
    int n, da;
    logic [DW-1:0] d;
    start_op(2'd3, 8'h77, 16'h0000);
    wait_idle(n, da);
    chk("R3 chip length", n, CT);
    chk("R3 chip done last", da, CT);
    rd(8'h00, d);  chk("R10 word 0", 32'(d), 32'hFFFF);
    rd(8'h3F, d);  chk("R10 word 3F", 32'(d), 32'hFFFF);
    rd(8'hFF, d);  chk("R10 last word", 32'(d), 32'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog_timing();
    t_prog_status();
    t_sector();
    t_block();
    t_ignore();
    t_chip();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule